// File: doc/BRIEF.md
# Arithmetic Status Flag Register

This block holds the 16-bit flag word of a small processor core and produces the status half of that word from an add or subtract. An operand pair, an operation select and a width select (byte or word) go into a combinational flag evaluator. A one-cycle update strobe captures six status bits: carry/borrow, parity, half-carry, zero, sign and overflow. Three control bits (single-step trap, maskable-interrupt enable and string direction) are held in separate storage. Each has its own set and clear strobe, and the update strobe does not touch them.

The packed word comes out on one port. Each flag sits at a fixed position and the unused positions are always zero. Sequencing logic reads the trap, interrupt-enable and direction bits from this word. Program-visible condition tests read the status bits.

Top module: `status_flag_reg`

## Requirements
- R1: After an active-low reset every bit of `flags` is 0.
- R2: Bit layout of `flags`: carry 0, parity 2, half-carry 4, zero 6, sign 7, trap 8, interrupt-enable 9, direction 10, overflow 11; bits 1, 3, 5, 12, 13, 14 and 15 always read 0.
- R3: When `upd` is high at a rising edge, the status bits show the new result from the next cycle on. When `upd` is low, the status bits keep their value.
- R4: Carry is the carry out of an add, or the borrow of a subtract (`op_sub`=1), at the selected width. With `op_word`=1 the width is 16 bits. With `op_word`=0 only the low 8 bits of each operand are used.
- R5: Parity is 1 when the low 8 bits of the result hold an even number of ones, and 0 when they hold an odd number. This applies at both widths.
- R6: Half-carry is the carry (add) or borrow (subtract) from bit 3 into bit 4.
- R7: Zero is 1 exactly when the result at the selected width is all zeros.
- R8: Sign equals the top bit of the result at the selected width (bit 7 or bit 15).
- R9: Overflow on add is set when both operands have the same sign and the result sign differs from it. On subtract it is set when the operand signs differ and the result sign differs from the minuend's sign.
- R10: `ctl_set[k]` sets control bit k and `ctl_clr[k]` clears it on the next edge (k=0 trap, 1 interrupt-enable, 2 direction). If both are high, clear wins.
- R11: The update strobe leaves the control bits unchanged, and the set/clear strobes leave the status bits unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | 16 | First operand (minuend on subtract) |
| op_b | input | 16 | Second operand (subtrahend on subtract) |
| op_sub | input | 1 | 1 = subtract, 0 = add |
| op_word | input | 1 | 1 = 16-bit operation, 0 = 8-bit operation |
| upd | input | 1 | Capture the status flags of the current operands |
| ctl_set | input | 3 | Per-bit set strobes for trap, interrupt-enable, direction |
| ctl_clr | input | 3 | Per-bit clear strobes, winning over set |
| flags | output | 16 | Packed flag word |

## Verification
The bench goes after results that cross a width boundary:
- A word add of 00FFh+1 must not report zero or carry. A design that took its width from the wrong byte would flag it as zero.
- Byte operations carry junk in the upper operand bytes. A design that let those bits leak in would give the wrong sign or carry.
- Signed wrap cases (7Fh+1, 80h−1, 8000h+8000h) catch an overflow test that has the subtract sign rule inverted.
- A result with a zero low byte but a nonzero upper byte catches parity computed over all 16 bits.
- The bench asserts set and clear together on the control bits. It interleaves arithmetic updates with control writes, which exposes clobbering in either direction.

// File: rtl/sflag_pkg.sv
// Package: shared widths and bit positions of the flag word.
// Assumes a 16-bit word holding byte and word operations.
package sflag_pkg;
    localparam int FLAG_W  = 16;
    localparam int DATA_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int CTL_N   = 3;
    localparam int NIB_W   = 4;

    localparam int POS_CF  = 0;
    localparam int POS_PF  = 2;
    localparam int POS_AF  = 4;
    localparam int POS_ZF  = 6;
    localparam int POS_SF  = 7;
    localparam int POS_TF  = 8;
    localparam int POS_IF  = 9;
    localparam int POS_DF  = 10;
    localparam int POS_OF  = 11;

    localparam logic [FLAG_W-1:0] STATUS_MASK = 16'h08D5;
    localparam logic [FLAG_W-1:0] CTL_MASK    = 16'h0700;

    typedef struct packed {
        logic of_f;
        logic sf_f;
        logic zf_f;
        logic af_f;
        logic pf_f;
        logic cf_f;
    } status_t;
endpackage

// File: rtl/sflag_arith.sv
// Module: sflag_arith
// Combinational evaluation of the six status flags for an add or subtract
// at byte or word width. Assumes BYTE_W divides DATA_W and NIB_W < BYTE_W.
module sflag_arith #(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8,
    parameter int NIB_W  = 4
) (
    input  logic                  sub_i,
    input  logic                  word_i,
    input  logic [DATA_W-1:0]     a_i,
    input  logic [DATA_W-1:0]     b_i,
    output sflag_pkg::status_t    st_o
);
    localparam int HI_W = DATA_W - BYTE_W;

    logic [DATA_W:0]   wide_res;
    logic [BYTE_W:0]   narrow_res;
    logic [DATA_W-1:0] res;
    logic              sgn_a, sgn_b, sgn_r;

    // Purpose: form both width results with the carry/borrow in the top bit.
    always_comb begin
        if (sub_i) begin
            wide_res   = {1'b0, a_i} - {1'b0, b_i};
            narrow_res = {1'b0, a_i[BYTE_W-1:0]} - {1'b0, b_i[BYTE_W-1:0]};
        end else begin
            wide_res   = {1'b0, a_i} + {1'b0, b_i};
            narrow_res = {1'b0, a_i[BYTE_W-1:0]} + {1'b0, b_i[BYTE_W-1:0]};
        end
    end

    // Purpose: pick the result and sign bits for the selected width.
    always_comb begin
        if (word_i) begin
            res   = wide_res[DATA_W-1:0];
            sgn_a = a_i[DATA_W-1];
            sgn_b = b_i[DATA_W-1];
        end else begin
            res   = {{HI_W{1'b0}}, narrow_res[BYTE_W-1:0]};
            sgn_a = a_i[BYTE_W-1];
            sgn_b = b_i[BYTE_W-1];
        end
        sgn_r = word_i ? res[DATA_W-1] : res[BYTE_W-1];
    end

    // Purpose: derive each status flag from the selected result.
    always_comb begin
        st_o.cf_f = word_i ? wide_res[DATA_W] : narrow_res[BYTE_W];
        st_o.pf_f = ~(^res[BYTE_W-1:0]);
        st_o.af_f = a_i[NIB_W] ^ b_i[NIB_W] ^ res[NIB_W];
        st_o.zf_f = (res == '0);
        st_o.sf_f = sgn_r;
        st_o.of_f = sub_i ? ((sgn_a != sgn_b) && (sgn_r != sgn_a))
                          : ((sgn_a == sgn_b) && (sgn_r != sgn_a));
    end
endmodule

// File: rtl/sflag_status_regs.sv
// Module: sflag_status_regs
// Holds the six status flags; loads them only on the update strobe.
// Assumes a synchronous active-low reset.
module sflag_status_regs (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  sflag_pkg::status_t d_i,
    output sflag_pkg::status_t q_o
);
    // Purpose: capture the evaluated status on load, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)      q_o <= '0;
        else if (load_i) q_o <= d_i;
    end
endmodule

// File: rtl/sflag_ctl_bits.sv
// Module: sflag_ctl_bits
// Independent set/clear storage for each control flag; clear has priority.
// Assumes a synchronous active-low reset.
module sflag_ctl_bits #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    for (genvar k = 0; k < N; k++) begin : g_bit
        // Purpose: one control flop with clear-over-set priority.
        always_ff @(posedge clk) begin
            if (!rst_n)        q_o[k] <= 1'b0;
            else if (clr_i[k]) q_o[k] <= 1'b0;
            else if (set_i[k]) q_o[k] <= 1'b1;
        end
    end
endmodule

// File: rtl/status_flag_reg.sv
// Module: status_flag_reg (top)
// Packs the status and control flags into the fixed 16-bit flag word.
// Assumes the operands are stable in the cycle where upd is high.
module status_flag_reg (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] op_a,
    input  logic [15:0] op_b,
    input  logic        op_sub,
    input  logic        op_word,
    input  logic        upd,
    input  logic [2:0]  ctl_set,
    input  logic [2:0]  ctl_clr,
    output logic [15:0] flags
);
    import sflag_pkg::*;

    status_t          st_next, st_q;
    logic [CTL_N-1:0] ctl_q;

    sflag_arith #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .NIB_W(NIB_W)) u_arith (
        .sub_i (op_sub),
        .word_i(op_word),
        .a_i   (op_a),
        .b_i   (op_b),
        .st_o  (st_next)
    );

    sflag_status_regs u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(upd),
        .d_i   (st_next),
        .q_o   (st_q)
    );

    sflag_ctl_bits #(.N(CTL_N)) u_ctl (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(ctl_set),
        .clr_i(ctl_clr),
        .q_o  (ctl_q)
    );

    // Purpose: place every flag at its fixed position; others stay zero.
    always_comb begin
        flags         = '0;
        flags[POS_CF] = st_q.cf_f;
        flags[POS_PF] = st_q.pf_f;
        flags[POS_AF] = st_q.af_f;
        flags[POS_ZF] = st_q.zf_f;
        flags[POS_SF] = st_q.sf_f;
        flags[POS_TF] = ctl_q[0];
        flags[POS_IF] = ctl_q[1];
        flags[POS_DF] = ctl_q[2];
        flags[POS_OF] = st_q.of_f;
    end
endmodule

// File: rtl/status_flag_reg_chk.sv
// Module: status_flag_reg_chk
// Port-level temporal checks on the flag word, bound into the top.
module status_flag_reg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] op_a,
    input logic [15:0] op_b,
    input logic        op_sub,
    input logic        op_word,
    input logic        upd,
    input logic [2:0]  ctl_set,
    input logic [2:0]  ctl_clr,
    input logic [15:0] flags
);
    import sflag_pkg::*;

    logic [DATA_W:0] ref_sum;
    assign ref_sum = {1'b0, op_a} + {1'b0, op_b};

    // R2: unused positions read zero
    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (flags & ~(STATUS_MASK | CTL_MASK)) == '0);

    // R3: status holds without update
    p_status_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(flags & STATUS_MASK));

    // R4: word add carry equals carry out of the operand sum
    p_word_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && op_word && !op_sub) |=> (flags[POS_CF] == $past(ref_sum[DATA_W])));

    // R5: a zero result has an even low byte
    p_zero_even_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flags[POS_ZF] |-> flags[POS_PF]);

    // R7: zero and negative exclude each other
    p_zero_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flags[POS_ZF] |-> !flags[POS_SF]);

    // R10: clear wins, set otherwise
    p_ctl_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_clr[0] |=> !flags[POS_TF]);
    p_ctl_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_set[1] && !ctl_clr[1]) |=> flags[POS_IF]);

    // R11: control bits untouched without set/clear strobes
    p_ctl_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_set == '0 && ctl_clr == '0) |=> $stable(flags & CTL_MASK));
endmodule

bind status_flag_reg status_flag_reg_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .op_a   (op_a),
    .op_b   (op_b),
    .op_sub (op_sub),
    .op_word(op_word),
    .upd    (upd),
    .ctl_set(ctl_set),
    .ctl_clr(ctl_clr),
    .flags  (flags)
);

// File: tb/status_flag_reg_tb.sv
module status_flag_reg_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] op_a = '0, op_b = '0;
    logic        op_sub = 1'b0, op_word = 1'b0, upd = 1'b0;
    logic [2:0]  ctl_set = '0, ctl_clr = '0;
    logic [15:0] flags;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    status_flag_reg u_dut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .op_sub(op_sub), .op_word(op_word), .upd(upd),
        .ctl_set(ctl_set), .ctl_clr(ctl_clr), .flags(flags)
    );

    // {sub, word, a, b, expected flag word}
    localparam int NV = 12;
    localparam logic [49:0] VEC [NV] = '{
        {1'b0, 1'b0, 16'h007F, 16'h0001, 16'h0890},
        {1'b0, 1'b0, 16'h00FF, 16'h0001, 16'h0055},
        {1'b1, 1'b0, 16'h0000, 16'h0001, 16'h0095},
        {1'b1, 1'b0, 16'h0080, 16'h0001, 16'h0810},
        {1'b0, 1'b1, 16'h7FFF, 16'h0001, 16'h0894},
        {1'b0, 1'b1, 16'hFFFF, 16'h0001, 16'h0055},
        {1'b0, 1'b1, 16'h00FF, 16'h0001, 16'h0014},
        {1'b1, 1'b1, 16'h1234, 16'h1234, 16'h0044},
        {1'b0, 1'b0, 16'hAB40, 16'hCD40, 16'h0880},
        {1'b1, 1'b1, 16'h0000, 16'h0001, 16'h0095},
        {1'b0, 1'b1, 16'h8000, 16'h8000, 16'h0845},
        {1'b1, 1'b0, 16'h0003, 16'h0008, 16'h0091}
    };

    task automatic check(input logic [15:0] exp, input string req);
        checks++;
        if (flags !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, flags, exp);
        end
    endtask

    task automatic run_op(input logic s, input logic w,
                          input logic [15:0] a, input logic [15:0] b);
        op_sub = s; op_word = w; op_a = a; op_b = b; upd = 1'b1;
        @(negedge clk);
        upd = 1'b0;
    endtask

    task automatic ctl_op(input logic [2:0] s, input logic [2:0] c);
        ctl_set = s; ctl_clr = c;
        @(negedge clk);
        ctl_set = '0; ctl_clr = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(16'h0000, "R1 reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R4 R5 R6 R7 R8 R9: table of status results
        for (int i = 0; i < NV; i++) begin
            run_op(VEC[i][49], VEC[i][48], VEC[i][47:32], VEC[i][31:16]);
            check(VEC[i][15:0], $sformatf("R4-flags vector %0d", i));
        end

        // R3: no update, operands change, status held
        op_a = 16'h0000; op_b = 16'h0000; op_sub = 1'b0;
        repeat (2) @(negedge clk);
        check(16'h0091, "R3 hold");

        // R10: set each control bit
        ctl_op(3'b001, 3'b000);
        check(16'h0191, "R10 set trap");
        ctl_op(3'b110, 3'b000);
        check(16'h0791, "R10 set ie/dir");
        // R10: clear beats set
        ctl_op(3'b010, 3'b010);
        check(16'h0591, "R10 clear wins");

        // R11: update leaves control bits
        run_op(1'b0, 1'b0, 16'h007F, 16'h0001);
        check(16'h0D90, "R11 update keeps control");
        ctl_op(3'b000, 3'b101);
        check(16'h0890, "R11 control keeps status");

        // R1: reset mid-run
        ctl_op(3'b111, 3'b000);
        rst_n = 1'b0;
        @(negedge clk);
        check(16'h0000, "R1 mid reset");
        rst_n = 1'b1;
        done = 1'b1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual timeout expected done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule